// File: doc/BRIEF.md
# CAN Interrupt Flag and Error Capture Register

This block turns the live status levels and event strobes of a CAN protocol engine into latched interrupt flags. It also freezes the details of the most recent bus error and lost arbitration. A 32-bit word shows the flags and the captured fields, and a single interrupt line is the OR of all flags. Each flag source has its own enable bit, supplied from outside on `irqEn`.

The flag triggers come in three kinds:
- Level: the receive flag tracks its condition on every cycle.
- Rising edge: the transmit-free flags and the overrun flag set when their status goes from 0 to 1.
- Any change: the error-warning and error-passive flags set when their status changes in either direction.

A bus error, an arbitration loss and an identifier strobe each set their flag directly.

Reads are signalled with `rdEn` and a byte-lane mask, and each lane has its own side effect:
- Lane 0 acknowledges the latched flags.
- Lane 2 re-arms the bus-error capture.
- Lane 3 re-arms the arbitration capture and clears its flag.

Top module: `canIrqCapture`

## Requirements
- R1: Bit 0 of `rdData` equals `rxFull & irqEn[0]` as sampled at the previous clock edge. It is a level and is never cleared by a read.
- R2: Bits 1, 9 and 10 set when `txFree[0]`, `txFree[1]` or `txFree[2]` respectively goes from 0 to 1 while enable bit 1, 9 or 10 respectively is 1. A steady 1 on `txFree` sets nothing.
- R3: Bit 2 sets when `errStatus` or `busStatus` changes value in either direction while `irqEn[2]` is 1.
- R4: Bit 3 sets when `overrun` rises while `irqEn[3]` is 1. Bit 4 sets on any cycle in which `sleeping`, `busActivity` and `irqEn[4]` are all 1.
- R5: Bit 5 sets when `errPassive` changes in either direction while `irqEn[5]` is 1. Bit 8 sets on an `idRcvd` strobe while `irqEn[8]` is 1.
- R6: An accepted `busErr` strobe has two effects:
  - It captures `busErrPos` into bits 20:16, `busErrRx` into bit 21 (1 receiving, 0 transmitting) and `busErrType` into bits 23:22 (00 bit, 01 form, 10 stuff, 11 other).
  - It sets bit 7 if `irqEn[7]` is 1.
- R7: After any accepted bus error, the capture locks whatever the enables are. Further `busErr` strobes change neither bits 23:16 nor bit 7 until a read with byte lane 2 releases the lock.
- R8: An accepted `arbLost` strobe captures `arbBit` into bits 28:24 (0 is the first identifier bit, 31 the extended remote bit) and sets bit 6 if `irqEn[6]` is 1. It locks the capture against later strobes until a read with byte lane 3, which also clears bit 6.
- R9: A read with byte lane 0 clears bits 10:1. A flag whose set condition is true in the same cycle as a clearing read stays set.
- R10: `irqOut` is the OR of bits 10:0. Bits 15:11 and 31:29 always read 0. After reset every bit of `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxFull | input | 1 | Receive buffer holds a message |
| txFree | input | 3 | Transmit buffer free flags |
| errStatus | input | 1 | Error-warning status level |
| busStatus | input | 1 | Bus-off status level |
| overrun | input | 1 | Data overrun status level |
| sleeping | input | 1 | Controller is in sleep |
| busActivity | input | 1 | Bus activity seen |
| errPassive | input | 1 | Controller is error passive |
| arbLost | input | 1 | Arbitration lost strobe |
| arbBit | input | 5 | Bit index of the arbitration loss |
| busErr | input | 1 | Bus error strobe |
| busErrPos | input | 5 | Frame position code of the error |
| busErrRx | input | 1 | Direction at the error (1 receive) |
| busErrType | input | 2 | Error type code |
| idRcvd | input | 1 | Identifier received strobe |
| irqEn | input | 11 | Per-flag enables, bit i gates flag i |
| rdEn | input | 1 | Register read strobe |
| rdByteMask | input | 4 | Byte lanes taking part in the read |
| rdData | output | 32 | Flags and captured fields |
| irqOut | output | 1 | OR of all flags |

## Verification
Every result is due exactly one edge after the input that causes it:
- Each flag, capture and lock updates at the edge that samples its stimulus.
- A read's side effects show one cycle after the read strobe.
- `rdData` and `irqOut` decode the registers combinationally.

The bench drives its inputs at the falling edge and advances its reference model at the rising edge. It compares the whole word at the next falling edge, so every result is checked in the cycle it is due. A mismatch is reported per field, under the requirement that field belongs to.

// File: rtl/canIrqPkg.sv
package canIrqPkg;
  localparam int FLAG_W = 11;
  localparam int POS_W  = 5;
  localparam int ARB_W  = 5;
  localparam int TYPE_W = 2;
  localparam int TX_N   = 3;

  localparam int RX_BIT  = 0;
  localparam int EW_BIT  = 2;
  localparam int DO_BIT  = 3;
  localparam int WU_BIT  = 4;
  localparam int EP_BIT  = 5;
  localparam int AL_BIT  = 6;
  localparam int BE_BIT  = 7;
  localparam int ID_BIT  = 8;

  function automatic int txFlagBit(input int idx);
    return (idx == 0) ? 1 : 8 + idx;
  endfunction

  typedef struct packed {
    logic [FLAG_W-1:0] setFlag;
    logic [FLAG_W-1:0] clrFlag;
    logic              capErr;
    logic              capArb;
  } ctlStrobes_t;
endpackage

// File: rtl/canIrqControl.sv
module canIrqControl
  import canIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxFull,
  input  logic [TX_N-1:0]   txFree,
  input  logic              errStatus,
  input  logic              busStatus,
  input  logic              overrun,
  input  logic              sleeping,
  input  logic              busActivity,
  input  logic              errPassive,
  input  logic              arbLost,
  input  logic              busErr,
  input  logic              idRcvd,
  input  logic [FLAG_W-1:0] irqEn,
  input  logic              rdEn,
  input  logic [3:0]        rdByteMask,
  output ctlStrobes_t       strb
);
  logic [TX_N-1:0] txFreePrev;
  logic errPrev, busPrev, ovrPrev, passPrev;
  logic errLock, arbLock;
  logic relErr, relArb, ackFlags;
  logic [FLAG_W-1:0] rawSet;

  assign ackFlags = rdEn & rdByteMask[0];
  assign relErr   = rdEn & rdByteMask[2];
  assign relArb   = rdEn & rdByteMask[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFreePrev <= '0;
      errPrev    <= 1'b0;
      busPrev    <= 1'b0;
      ovrPrev    <= 1'b0;
      passPrev   <= 1'b0;
    end else begin
      txFreePrev <= txFree;
      errPrev    <= errStatus;
      busPrev    <= busStatus;
      ovrPrev    <= overrun;
      passPrev   <= errPassive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errLock <= 1'b0;
      arbLock <= 1'b0;
    end else begin
      if (strb.capErr)  errLock <= 1'b1;
      else if (relErr)  errLock <= 1'b0;
      if (strb.capArb)  arbLock <= 1'b1;
      else if (relArb)  arbLock <= 1'b0;
    end
  end

  always_comb begin
    rawSet = '0;
    rawSet[RX_BIT] = rxFull;
    rawSet[EW_BIT] = (errStatus ^ errPrev) | (busStatus ^ busPrev);
    rawSet[DO_BIT] = overrun & ~ovrPrev;
    rawSet[WU_BIT] = sleeping & busActivity;
    rawSet[EP_BIT] = errPassive ^ passPrev;
    rawSet[AL_BIT] = arbLost & ~arbLock;
    rawSet[BE_BIT] = busErr & ~errLock;
    rawSet[ID_BIT] = idRcvd;
    for (int i = 0; i < TX_N; i++)
      rawSet[txFlagBit(i)] = txFree[i] & ~txFreePrev[i];
  end

  always_comb begin
    strb.setFlag = rawSet & irqEn;
    strb.clrFlag = '0;
    if (ackFlags) strb.clrFlag[FLAG_W-1:1] = '1;
    if (relArb)   strb.clrFlag[AL_BIT] = 1'b1;
    strb.capErr = busErr & ~errLock;
    strb.capArb = arbLost & ~arbLock;
  end

  assert_err_lock_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errLock && !relErr) |=> errLock);
  assert_arb_lock_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (arbLock && !relArb) |=> arbLock);
  assert_no_cap_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    errLock |-> !strb.capErr);
endmodule

// File: rtl/canIrqDatapath.sv
module canIrqDatapath
  import canIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ARB_W-1:0]  arbBit,
  input  logic [POS_W-1:0]  busErrPos,
  input  logic              busErrRx,
  input  logic [TYPE_W-1:0] busErrType,
  output logic [31:0]       rdData,
  output logic              irqOut
);
  localparam int ERR_W = POS_W + 1 + TYPE_W;

  logic [FLAG_W-1:0] flags;
  logic [ERR_W-1:0]  errField;
  logic [ARB_W-1:0]  arbField;

  for (genvar i = 0; i < FLAG_W; i++) begin : gFlag
    if (i == RX_BIT) begin : gLevel
      always_ff @(posedge clk) begin
        if (!rstN) flags[i] <= 1'b0;
        else       flags[i] <= strb.setFlag[i];
      end
    end else begin : gSticky
      always_ff @(posedge clk) begin
        if (!rstN)                 flags[i] <= 1'b0;
        else if (strb.setFlag[i])  flags[i] <= 1'b1;
        else if (strb.clrFlag[i])  flags[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errField <= '0;
      arbField <= '0;
    end else begin
      if (strb.capErr) errField <= {busErrType, busErrRx, busErrPos};
      if (strb.capArb) arbField <= arbBit;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[FLAG_W-1:0]   = flags;
    rdData[16+:ERR_W]    = errField;
    rdData[24+:ARB_W]    = arbField;
  end
  assign irqOut = |flags;

  assert_err_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capErr |=> $stable(errField));
  assert_arb_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capArb |=> $stable(arbField));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlag[DO_BIT] |=> flags[DO_BIT]);
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag[DO_BIT] && !strb.setFlag[DO_BIT]) |=> !flags[DO_BIT]);
endmodule

// File: rtl/canIrqCapture.sv
module canIrqCapture
  import canIrqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxFull,
  input  logic [2:0]  txFree,
  input  logic        errStatus,
  input  logic        busStatus,
  input  logic        overrun,
  input  logic        sleeping,
  input  logic        busActivity,
  input  logic        errPassive,
  input  logic        arbLost,
  input  logic [4:0]  arbBit,
  input  logic        busErr,
  input  logic [4:0]  busErrPos,
  input  logic        busErrRx,
  input  logic [1:0]  busErrType,
  input  logic        idRcvd,
  input  logic [10:0] irqEn,
  input  logic        rdEn,
  input  logic [3:0]  rdByteMask,
  output logic [31:0] rdData,
  output logic        irqOut
);
  ctlStrobes_t strb;

  canIrqControl uCtl (
    .clk(clk), .rstN(rstN), .rxFull(rxFull), .txFree(txFree),
    .errStatus(errStatus), .busStatus(busStatus), .overrun(overrun),
    .sleeping(sleeping), .busActivity(busActivity), .errPassive(errPassive),
    .arbLost(arbLost), .busErr(busErr), .idRcvd(idRcvd), .irqEn(irqEn),
    .rdEn(rdEn), .rdByteMask(rdByteMask), .strb(strb)
  );

  canIrqDatapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .arbBit(arbBit),
    .busErrPos(busErrPos), .busErrRx(busErrRx), .busErrType(busErrType),
    .rdData(rdData), .irqOut(irqOut)
  );

  assert_tx_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[1]) |-> $past(txFree[0]));
  assert_irq_or_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (rdData[10:0] != 0));
endmodule

// File: tb/canIrqCapture_test.sv
module canIrqCapture_test;
  logic clk = 1'b0;
  logic rstN;
  logic rxFull, errStatus, busStatus, overrun, sleeping, busActivity, errPassive;
  logic arbLost, busErr, busErrRx, idRcvd, rdEn;
  logic [2:0] txFree;
  logic [4:0] arbBit, busErrPos;
  logic [1:0] busErrType;
  logic [10:0] irqEn;
  logic [3:0] rdByteMask;
  logic [31:0] rdData;
  logic irqOut;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  canIrqCapture uut (.*);

  // reference model state
  bit [10:0] mFlags;
  bit [4:0] mPos, mArb;
  bit mDir, mErrLock, mArbLock;
  bit [1:0] mType;
  bit [2:0] pTx;
  bit pErr, pBus, pOvr, pPass;

  always @(posedge clk) begin
    if (!rstN) begin
      mFlags = 0; mPos = 0; mArb = 0; mDir = 0; mType = 0;
      mErrLock = 0; mArbLock = 0; pTx = 0; pErr = 0; pBus = 0; pOvr = 0; pPass = 0;
    end else begin
      bit [10:0] nf;
      bit ack, rel2, rel3, newErrLock, newArbLock;
      ack = rdEn && rdByteMask[0];
      rel2 = rdEn && rdByteMask[2];
      rel3 = rdEn && rdByteMask[3];
      nf = mFlags;
      if (ack) nf[10:1] = 0;
      if (rel3) nf[6] = 0;
      nf[0] = rxFull && irqEn[0];
      if (txFree[0] && !pTx[0] && irqEn[1]) nf[1] = 1;
      if (txFree[1] && !pTx[1] && irqEn[9]) nf[9] = 1;
      if (txFree[2] && !pTx[2] && irqEn[10]) nf[10] = 1;
      if (((errStatus != pErr) || (busStatus != pBus)) && irqEn[2]) nf[2] = 1;
      if (overrun && !pOvr && irqEn[3]) nf[3] = 1;
      if (sleeping && busActivity && irqEn[4]) nf[4] = 1;
      if ((errPassive != pPass) && irqEn[5]) nf[5] = 1;
      if (idRcvd && irqEn[8]) nf[8] = 1;
      newErrLock = mErrLock;
      newArbLock = mArbLock;
      if (rel2) newErrLock = 0;
      if (rel3) newArbLock = 0;
      if (busErr && !mErrLock) begin
        mPos = busErrPos; mDir = busErrRx; mType = busErrType;
        newErrLock = 1;
        if (irqEn[7]) nf[7] = 1;
      end
      if (arbLost && !mArbLock) begin
        mArb = arbBit; newArbLock = 1;
        if (irqEn[6]) nf[6] = 1;
      end
      mFlags = nf; mErrLock = newErrLock; mArbLock = newArbLock;
      pTx = txFree; pErr = errStatus; pBus = busStatus; pOvr = overrun; pPass = errPassive;
    end
  end

  function automatic string tagOf(input int b);
    case (b)
      0: return "R1";
      1, 9, 10: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5, 8: return "R5";
      6: return "R8";
      7: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic compareNow();
    bit [31:0] exp;
    bit expIrq;
    bit bad;
    exp = {3'b0, mArb, mType, mDir, mPos, 5'b0, mFlags};
    expIrq = |mFlags;
    bad = 0;
    vectors++;
    for (int b = 0; b < 11; b++)
      if (rdData[b] !== exp[b]) begin
        $display("FAIL %s flag bit %0d: got %b expected %b", tagOf(b), b, rdData[b], exp[b]);
        bad = 1;
      end
    if (rdData[23:16] !== exp[23:16]) begin
      $display("FAIL R6/R7 error capture: got %h expected %h", rdData[23:16], exp[23:16]);
      bad = 1;
    end
    if (rdData[28:24] !== exp[28:24]) begin
      $display("FAIL R8 arbitration capture: got %h expected %h", rdData[28:24], exp[28:24]);
      bad = 1;
    end
    if (rdData[15:11] !== 5'b0 || rdData[31:29] !== 3'b0) begin
      $display("FAIL R10 reserved bits: got %h expected 0", rdData);
      bad = 1;
    end
    if (irqOut !== expIrq) begin
      $display("FAIL R10 irqOut: got %b expected %b", irqOut, expIrq);
      bad = 1;
    end
    if (bad) miscompares++;
  endtask

  task automatic quiet();
    rxFull = 0; txFree = 0; errStatus = 0; busStatus = 0; overrun = 0;
    sleeping = 0; busActivity = 0; errPassive = 0; arbLost = 0; arbBit = 0;
    busErr = 0; busErrPos = 0; busErrRx = 0; busErrType = 0; idRcvd = 0;
    rdEn = 0; rdByteMask = 0;
  endtask

  // one cycle: check at falling edge, then apply the stimulus prepared by caller
  task automatic step();
    @(negedge clk);
    if (rstN) compareNow();
  endtask

  task automatic clearStrobes();
    arbLost = 0; busErr = 0; idRcvd = 0; rdEn = 0; rdByteMask = 0; busActivity = 0;
  endtask

  initial begin
    quiet();
    irqEn = '1;
    rstN = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    vectors++;
    if (rdData !== 32'h0 || irqOut !== 1'b0) begin
      miscompares++;
      $display("FAIL R10 reset: got %h/%b expected 0/0", rdData, irqOut);
    end
    rstN = 1;
    step();
    // R1 level receive
    rxFull = 1; step(); step();
    rxFull = 0; step();
    // R2 transmit edges, steady high
    txFree = 3'b101; step(); step(); step();
    rdEn = 1; rdByteMask = 4'b0001; step(); clearStrobes(); step();
    // R3 any change, falling too
    errStatus = 1; step(); rdEn = 1; rdByteMask = 1; step(); clearStrobes();
    errStatus = 0; step(); busStatus = 1; step(); step();
    // R4 overrun, wake-up
    overrun = 1; step(); overrun = 0; sleeping = 1; busActivity = 1; step(); clearStrobes(); step();
    // R5 passive toggles, identifier
    errPassive = 1; step(); errPassive = 0; idRcvd = 1; step(); clearStrobes(); step();
    // R6 bus error capture: position DLC 01011, receiving, stuff error
    busErr = 1; busErrPos = 5'b01011; busErrRx = 1; busErrType = 2'b10; step();
    // R7 second error while locked is ignored
    busErrPos = 5'b00011; busErrRx = 0; busErrType = 2'b01; step(); clearStrobes(); step();
    rdEn = 1; rdByteMask = 4'b0100; step(); clearStrobes();
    busErr = 1; busErrPos = 5'b11001; busErrType = 2'b11; step(); clearStrobes(); step();
    // R8 arbitration capture, lock, lane-3 release
    arbLost = 1; arbBit = 5'd31; step(); arbBit = 5'd4; step(); clearStrobes(); step();
    rdEn = 1; rdByteMask = 4'b1000; step(); clearStrobes(); step();
    arbLost = 1; arbBit = 5'd0; step(); clearStrobes();
    // R9 set wins over same-cycle ack
    overrun = 0; step(); overrun = 1; rdEn = 1; rdByteMask = 4'b0001; step(); clearStrobes(); step();
    // disabled sources: bus error locks capture without flag
    rdEn = 1; rdByteMask = 4'b1111; step(); clearStrobes();
    irqEn = 11'h000; busErr = 1; busErrPos = 5'b01000; step(); clearStrobes();
    txFree = 0; step(); txFree = 3'b111; step(); step();
    irqEn = '1; rdEn = 1; rdByteMask = 4'b0100; step(); clearStrobes(); step();
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      rxFull = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) txFree = 3'($urandom);
      if ($urandom_range(0, 9) == 0) errStatus = ~errStatus;
      if ($urandom_range(0, 11) == 0) busStatus = ~busStatus;
      if ($urandom_range(0, 7) == 0) overrun = ~overrun;
      if ($urandom_range(0, 13) == 0) errPassive = ~errPassive;
      sleeping = ($urandom_range(0, 3) == 0);
      busActivity = ($urandom_range(0, 3) == 0);
      arbLost = ($urandom_range(0, 9) == 0); arbBit = 5'($urandom);
      busErr = ($urandom_range(0, 9) == 0); busErrPos = 5'($urandom);
      busErrRx = 1'($urandom); busErrType = 2'($urandom);
      idRcvd = ($urandom_range(0, 9) == 0);
      irqEn = ($urandom_range(0, 15) == 0) ? 11'($urandom) : irqEn;
      rdEn = ($urandom_range(0, 5) == 0); rdByteMask = 4'($urandom);
      step();
    end
    quiet(); step();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule